// File: doc/BRIEF.md
# Cipher Result Ready Flag Controller

This block is the control and status shell that sits in front of a 64-bit block-cipher engine. Software loads a 64-bit operand as two 32-bit input words, starts the engine, and collects the 64-bit result from two output words. A ready flag reports that a result is waiting. Completion can also be reported through an interrupt line. The cipher itself is modelled by a stub that XORs the operand with a fixed key after a fixed number of cycles.

The engine can be started in two ways. In command mode, software writes a start bit. In self-start mode, the engine starts once both input words have been loaded. The ready flag is cleared by one of two bus events, selected by a mode bit. Normally, reading a result word clears the flag. In chained mode, writing the next operand clears it instead. Chained mode suits MAC generation with CBC or CFB chaining, where only the result of the last step is of interest and software never has to read the intermediate results. A completion flag from an external DMA engine enters as a level input and can also raise the interrupt.

Top module: `cipher_flag_ctrl`

## Requirements
- R1: After reset, every readable register reads zero and `irq` is low. The register map is: 0 command, 1 mode, 2 irq-set, 3 irq-clear, 4 irq-mask, 5 status, 6 operand low, 7 operand high, 8 result low, 9 result high. Unmapped addresses read zero.
- R2: In command mode (mode bit1 = 0), writing 1 to command bit0 while idle starts an operation. Status bit2 (busy) then reads 1 for exactly LATENCY cycles. On the cycle busy falls, result high:low is loaded with {operand high, operand low} ^ KEY, and status bit0 (ready) sets on the same cycle.
- R3: In self-start mode (mode bit1 = 1), a command write has no effect. An operation starts on the cycle after the second of the two operand words has been written since the last start.
- R4: While busy, a command write is ignored, and operand writes do not count towards a self-start. The running operation keeps the operand it latched at its start.
- R5: With chained mode off (mode bit0 = 0), reading either result word clears ready. Writing an operand word does not clear it.
- R6: With chained mode off, if ready is never cleared, it stays set across later completions. The result words still update, and `irq` gives no new edge.
- R7: With chained mode on (mode bit0 = 1), writing either operand word clears ready. Reading the result words does not clear it.
- R8: A completion on the same cycle as a clearing event leaves ready set.
- R9: Writing 1s to irq-set sets the matching mask bits, and writing 1s to irq-clear clears them. Zero bits have no effect. The 2-bit mask reads back at address 4.
- R10: Status bit1 reflects `dma_done`. `irq` is high exactly when (ready and mask bit0) or (`dma_done` and mask bit1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects apply at the clock edge) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| dma_done | input | 1 | Completion level from an external DMA engine |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with LATENCY = 3 and a key that differs in every byte. The short latency lets the bench issue command and operand writes inside the busy window, and lets it place a result read on exactly the completion edge. The key makes every result word differ from its operand, so a result loaded from the wrong word or at the wrong time shows up at once.

// File: rtl/cipher_flag_ctrl.sv
module cipher_flag_ctrl #(
  parameter int          LATENCY = 12,
  parameter logic [63:0] KEY     = 64'h3C5A_96F0_0FF0_A55A
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        dma_done,
  output logic        irq
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [3:0] A_CMD = 4'd0, A_MODE = 4'd1, A_ISET = 4'd2, A_ICLR = 4'd3,
                         A_MASK = 4'd4, A_STAT = 4'd5, A_IN0 = 4'd6, A_IN1 = 4'd7,
                         A_OUT0 = 4'd8, A_OUT1 = 4'd9;

  logic [31:0]   in0, in1;
  logic [63:0]   op, res;
  logic [1:0]    mask;
  logic [CW-1:0] cnt;
  logic          lod, auto_m, ready, busy, seen0, seen1;
  logic          wr_in0, wr_in1, rd_out, start, done, clr;

  assign wr_in0 = bus_wr && bus_addr == A_IN0;
  assign wr_in1 = bus_wr && bus_addr == A_IN1;
  assign rd_out = bus_rd && (bus_addr == A_OUT0 || bus_addr == A_OUT1);
  assign done   = busy && cnt == CW'(1);
  assign start  = !busy && (auto_m ? (seen0 && seen1)
                                   : (bus_wr && bus_addr == A_CMD && bus_wdata[0]));
  assign clr    = lod ? (wr_in0 || wr_in1) : rd_out;
  assign irq    = (ready && mask[0]) || (dma_done && mask[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in0 <= '0; in1 <= '0; op <= '0; res <= '0; mask <= '0; cnt <= '0;
      lod <= 1'b0; auto_m <= 1'b0; ready <= 1'b0; busy <= 1'b0;
      seen0 <= 1'b0; seen1 <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_MODE) {auto_m, lod} <= bus_wdata[1:0];
      if (bus_wr && bus_addr == A_ISET) mask <= mask | bus_wdata[1:0];
      if (bus_wr && bus_addr == A_ICLR) mask <= mask & ~bus_wdata[1:0];
      if (wr_in0) in0 <= bus_wdata;
      if (wr_in1) in1 <= bus_wdata;
      seen0 <= start ? 1'b0 : (seen0 || (wr_in0 && !busy));
      seen1 <= start ? 1'b0 : (seen1 || (wr_in1 && !busy));
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(LATENCY);
        op   <= {in1, in0};
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (done) begin
          busy <= 1'b0;
          res  <= op ^ KEY;
        end
      end
      if (done)     ready <= 1'b1;
      else if (clr) ready <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {30'd0, auto_m, lod};
      A_MASK:  bus_rdata = {30'd0, mask};
      A_STAT:  bus_rdata = {29'd0, busy, dma_done, ready};
      A_IN0:   bus_rdata = in0;
      A_IN1:   bus_rdata = in1;
      A_OUT0:  bus_rdata = res[31:0];
      A_OUT1:  bus_rdata = res[63:32];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cipher_flag_ctrl_chk.sv
module cipher_flag_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        ready,
  input logic        busy,
  input logic        lod,
  input logic        auto_m,
  input logic        done,
  input logic [63:0] op,
  input logic [1:0]  mask,
  input logic        irq
);
  logic rd_res, wr_opnd;
  assign rd_res  = bus_rd && (bus_addr == 4'd8 || bus_addr == 4'd9);
  assign wr_opnd = bus_wr && (bus_addr == 4'd6 || bus_addr == 4'd7);

  assert_manual_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !auto_m && bus_wr && bus_addr == 4'd0 && bus_wdata[0]) |=> busy);
  assert_operand_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(op));
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lod && rd_res && !done) |=> !ready);
  assert_flag_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lod && ready && !rd_res) |=> ready);
  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lod && wr_opnd && !done) |=> !ready);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ready && !busy));
  assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd2 && bus_wdata[0]) |=> mask[0]);
  assert_irq_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && mask[0]) |-> irq);
endmodule

bind cipher_flag_ctrl cipher_flag_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ready(ready), .busy(busy), .lod(lod), .auto_m(auto_m),
  .done(done), .op(op), .mask(mask), .irq(irq)
);

// File: tb/cipher_flag_ctrl_test.sv
module cipher_flag_ctrl_test;
  localparam int          LAT = 3;
  localparam logic [63:0] K   = 64'hA5A5_5A5A_0F0F_F0F0;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, dma_done = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cipher_flag_ctrl #(.LATENCY(LAT), .KEY(K)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_done(dma_done), .irq(irq));

  // behavioural reference model
  bit m_ready = 0, m_busy = 0, m_lod = 0, m_auto = 0, m_s0 = 0, m_s1 = 0;
  bit st, dn, clr, ob;
  logic [1:0]  m_mask = '0;
  int          m_cnt = 0;
  logic [31:0] m_in0 = '0, m_in1 = '0;
  logic [63:0] m_op = '0, m_out = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      ob  = m_busy;
      st  = !ob && (m_auto ? (m_s0 && m_s1) : (bus_wr && bus_addr == 4'd0 && bus_wdata[0]));
      dn  = ob && m_cnt == 1;
      clr = m_lod ? (bus_wr && (bus_addr == 4'd6 || bus_addr == 4'd7))
                  : (bus_rd && (bus_addr == 4'd8 || bus_addr == 4'd9));
      if (st) begin
        m_busy = 1; m_cnt = LAT; m_op = {m_in1, m_in0}; m_s0 = 0; m_s1 = 0;
      end else begin
        if (ob) m_cnt = m_cnt - 1;
        if (dn) begin m_busy = 0; m_out = m_op ^ K; end
        if (bus_wr && bus_addr == 4'd6 && !ob) m_s0 = 1;
        if (bus_wr && bus_addr == 4'd7 && !ob) m_s1 = 1;
      end
      if (dn) m_ready = 1; else if (clr) m_ready = 0;
      if (bus_wr) begin
        case (bus_addr)
          4'd1: begin m_lod = bus_wdata[0]; m_auto = bus_wdata[1]; end
          4'd2: m_mask = m_mask | bus_wdata[1:0];
          4'd3: m_mask = m_mask & ~bus_wdata[1:0];
          4'd6: m_in0 = bus_wdata;
          4'd7: m_in1 = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    case (a)
      4'd1: return {30'd0, m_auto, m_lod};
      4'd4: return {30'd0, m_mask};
      4'd5: return {29'd0, m_busy, dma_done, m_ready};
      4'd6: return m_in0;
      4'd7: return m_in1;
      4'd8: return m_out[31:0];
      4'd9: return m_out[63:32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd8, 4'd9: return "R2";
      4'd5:       return "R5";
      4'd4:       return "R9";
      4'd1:       return "R3";
      default:    return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (irq !== ((m_ready && m_mask[0]) || (dma_done && m_mask[1]))) begin
        failures++;
        $display("FAIL R10 model irq actual=%0b expected=%0b", irq,
                 (m_ready && m_mask[0]) || (dma_done && m_mask[1]));
      end
      if (bus_rd) begin
        checks++;
        if (bus_rdata !== model_rd(bus_addr)) begin
          failures++;
          $display("FAIL %s model addr=%0d actual=%h expected=%h", tag_of(bus_addr),
                   bus_addr, bus_rdata, model_rd(bus_addr));
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      bus_rd = 0; bus_wr = 0;
    end
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    bus_wr = 0; bus_rd = 1; bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(posedge clk); #2;
    bus_wr = 0; bus_rd = 0;
    #1;
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    rd_chk(4'd5, 32'd0, "R1");
    rd_chk(4'd4, 32'd0, "R1");
    rd_chk(4'd8, 32'd0, "R1");
    rd_chk(4'd1, 32'd0, "R1");
    // R2 command start, exact latency
    wr(4'd6, 32'h1111_1111);
    wr(4'd7, 32'h2222_2222);
    wr(4'd0, 32'd1);
    rd_chk(4'd5, 32'd4, "R2");
    rd_chk(4'd5, 32'd4, "R2");
    rd_chk(4'd5, 32'd4, "R2");
    rd_chk(4'd5, 32'd1, "R2");
    rd_chk(4'd8, 32'h1E1E_E1E1, "R2");
    rd_chk(4'd9, 32'h8787_7878, "R2");
    rd_chk(4'd5, 32'd0, "R5");
    // R4 start while busy ignored, operand kept
    wr(4'd6, 32'h3333_3333);
    wr(4'd0, 32'd1);
    wr(4'd6, 32'h4444_4444);
    wr(4'd0, 32'd1);
    idle(4);
    rd_chk(4'd5, 32'd1, "R4");
    rd_chk(4'd8, 32'h3C3C_C3C3, "R4");
    // R5 operand write does not clear in normal mode
    wr(4'd0, 32'd1);
    idle(4);
    wr(4'd7, 32'h5555_5555);
    rd_chk(4'd5, 32'd1, "R5");
    rd_chk(4'd9, 32'h8787_7878, "R5");
    rd_chk(4'd5, 32'd0, "R5");
    // R6 unread flag sticks across completions
    wr(4'd2, 32'd1);
    wr(4'd0, 32'd1);
    idle(4);
    irq_chk(1'b1, "R10");
    wr(4'd0, 32'd1);
    irq_chk(1'b1, "R6");
    idle(4);
    rd_chk(4'd5, 32'd1, "R6");
    rd_chk(4'd9, 32'hF0F0_0F0F, "R6");
    rd_chk(4'd8, 32'h4B4B_B4B4, "R6");
    rd_chk(4'd5, 32'd0, "R5");
    // R9 mask set/clear, R10 dma path
    wr(4'd3, 32'd1);
    rd_chk(4'd4, 32'd0, "R9");
    wr(4'd2, 32'd3);
    wr(4'd3, 32'd0);
    rd_chk(4'd4, 32'd3, "R9");
    @(posedge clk); #2 bus_rd = 0; bus_wr = 0; dma_done = 1;
    irq_chk(1'b1, "R10");
    rd_chk(4'd5, 32'd2, "R10");
    wr(4'd3, 32'd2);
    irq_chk(1'b0, "R10");
    @(posedge clk); #2 bus_rd = 0; bus_wr = 0; dma_done = 0;
    // R7 chained mode
    wr(4'd1, 32'd1);
    wr(4'd0, 32'd1);
    idle(4);
    rd_chk(4'd5, 32'd1, "R7");
    rd_chk(4'd8, 32'h4B4B_B4B4, "R7");
    rd_chk(4'd5, 32'd1, "R7");
    wr(4'd6, 32'h6666_6666);
    rd_chk(4'd5, 32'd0, "R7");
    // R3 self-start mode
    wr(4'd1, 32'd3);
    rd_chk(4'd1, 32'd3, "R3");
    wr(4'd0, 32'd1);
    rd_chk(4'd5, 32'd0, "R3");
    wr(4'd6, 32'h0123_4567);
    wr(4'd7, 32'h89AB_CDEF);
    rd_chk(4'd5, 32'd0, "R3");
    rd_chk(4'd5, 32'd4, "R3");
    wr(4'd6, 32'd0);
    wr(4'd7, 32'd0);
    idle(2);
    rd_chk(4'd5, 32'd1, "R4");
    rd_chk(4'd8, 32'h0E2C_B597, "R3");
    rd_chk(4'd9, 32'h2C0E_97B5, "R3");
    rd_chk(4'd5, 32'd1, "R4");
    // R8 completion beats a same-cycle clear
    wr(4'd1, 32'd0);
    wr(4'd0, 32'd1);
    idle(2);
    rd_chk(4'd8, 32'h0E2C_B597, "R8");
    rd_chk(4'd5, 32'd1, "R8");
    rd_chk(4'd8, 32'h0F0F_F0F0, "R8");
    idle(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule